// File: doc/BRIEF.md
# Programmable Interrupt Controller With Critical Routing

The controller collects 26 interrupt request lines into two requests for a processor core: a non-critical one and a critical one. Sources 0 to 6 come from external pins and are first re-timed into the clock domain. Sources 7 to 25 come from on-chip logic and are used as they are. Software sets four things for each source through a small register port: how it is sensed (level or edge), its active polarity, whether it is enabled, and which output it drives.

When several critical sources are pending at once, a single order bit picks the winner: either the lowest or the highest pending index. The controller also forms a dispatch address for the winner, so the handler can branch straight to that source's routine. The address is a programmable base plus the winner's index times 512 bytes. When nothing critical is pending, the address is the base itself.

Each source has its own small state machine with three states:
- SRC_IDLE: nothing is pending.
- SRC_HELD: an edge has been latched.
- SRC_LIVE: a level input is active.

The transitions are:
- SRC_IDLE to SRC_HELD on an active edge in edge mode.
- SRC_IDLE to SRC_LIVE on an active input in level mode.
- SRC_HELD to SRC_IDLE on a write-1 clear when no new edge arrives in the same cycle.
- SRC_LIVE to SRC_IDLE when the input goes inactive.
- Switching the mode moves a held or live source to the state that matches the new mode.

The register port has its own two-state machine:
- BUS_IDLE goes to BUS_RESP on a read.
- BUS_RESP stays in BUS_RESP while reads continue, and returns to BUS_IDLE otherwise.

Top module: `irq_router`

## Requirements
- R1: After reset, both interrupt outputs are low, `crit_vector` is 0 and `reg_rvalid` is low. The reset values of the registers are: status 0, enable 0, edge mode 0, polarity all ones (0x3FFFFFF), route 0, order 0, base 0.
- R2: A read on cycle N raises `reg_rvalid` on cycle N+1, with `reg_rdata` holding the addressed register. A write takes effect at the clock edge that samples it. The word addresses are:
  - 0: raw status. Writing 1 to a bit clears that edge-latched bit.
  - 1: enable.
  - 2: masked status (read only).
  - 3: edge mode (1 = edge).
  - 4: polarity (1 = high or rising).
  - 5: route (1 = critical).
  - 6: order (bit 0).
  - 7: vector base.
  - 8: current vector (read only).
- R3: In level mode, a source's status bit follows the polarity-adjusted input, one clock after an on-chip input changes. Writing 1 to that bit while the input is active has no effect.
- R4: In edge mode, the active edge sets the status bit. The bit stays set after the input returns to idle, until software writes 1 to it at address 0.
- R5: Polarity bit 1 makes high (level mode) or rising (edge mode) the active condition. Polarity bit 0 makes low or falling the active condition.
- R6: An external input (sources 0 to 6) passes through two flip-flops. A change before clock edge N appears in the status at edge N+2. An on-chip input appears at edge N.
- R7: Masked status is raw status AND enable. A disabled source keeps its raw status bit but drives neither output.
- R8: `irq_crit` is the OR of the masked bits whose route bit is 1. `irq_noncrit` is the OR of the masked bits whose route bit is 0.
- R9: Order bit 0 = 0 makes the lowest pending critical index win. Order bit 0 = 1 makes the highest pending critical index win.
- R10: `crit_vector` equals base + winner index × 512 while a critical source is pending. It equals base when none is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_irq | input | 7 | External request pins, sources 0 to 6 |
| int_irq | input | 19 | On-chip requests, sources 7 to 25 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with `reg_rvalid` |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| irq_noncrit | output | 1 | Non-critical request to the core |
| irq_crit | output | 1 | Critical request to the core |
| crit_vector | output | 32 | Dispatch address of the winning critical source |

## Verification
Read data is due exactly one clock after the read strobe. The bench's driver queues the expected word at the read, and its monitor compares on the falling edge after the next rising edge. An on-chip request reaches the status and both outputs one rising edge after the bench changes it. An external request takes three rising edges, and the bench samples the output after each of the first two edges to confirm it is still low, then after the third to see it rise. Configuration writes and write-1 clears act at the edge that samples them. The vector and the outputs follow combinationally from state, so they are checked on the falling edge that follows each write or input change.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int DEF_N_EXT       = 7;
    localparam int DEF_N_INT       = 19;
    localparam int DEF_DATA_W      = 32;
    localparam int DEF_STRIDE_LOG2 = 9;
    localparam int REG_ADDR_W      = 4;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_STATUS = 4'd0,
        REG_ENABLE = 4'd1,
        REG_MASKED = 4'd2,
        REG_EDGE   = 4'd3,
        REG_POL    = 4'd4,
        REG_ROUTE  = 4'd5,
        REG_ORDER  = 4'd6,
        REG_VBASE  = 4'd7,
        REG_VECTOR = 4'd8
    } reg_sel_e;

    typedef enum logic [1:0] {
        SRC_IDLE = 2'd0,
        SRC_HELD = 2'd1,
        SRC_LIVE = 2'd2
    } src_state_e;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic pos_pol,
    input  logic edge_mode,
    input  logic clr,
    output logic status
);

    logic       act;
    logic       prev_q;
    logic       edge_hit;
    src_state_e state_q;
    src_state_e state_d;

    // polarity-adjusted request and its rising transition
    assign act      = pos_pol ? raw_in : ~raw_in;
    assign edge_hit = act & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            state_q <= SRC_IDLE;
        end else begin
            prev_q  <= act;
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_IDLE: begin
                if (edge_mode) begin
                    if (edge_hit) state_d = SRC_HELD;
                end else if (act) begin
                    state_d = SRC_LIVE;
                end
            end
            SRC_HELD: begin
                if (!edge_mode)              state_d = act ? SRC_LIVE : SRC_IDLE;
                else if (clr && !edge_hit)   state_d = SRC_IDLE;
            end
            SRC_LIVE: begin
                if (edge_mode)  state_d = edge_hit ? SRC_HELD : SRC_IDLE;
                else if (!act)  state_d = SRC_IDLE;
            end
            default: state_d = SRC_IDLE;
        endcase
    end

    always_comb begin
        status = (state_q != SRC_IDLE);
    end

endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int N_SRC       = 26,
    parameter int DATA_W      = 32,
    parameter int STRIDE_LOG2 = 9
) (
    input  logic [N_SRC-1:0]  pend,
    input  logic              hi_first,
    input  logic [DATA_W-1:0] vbase,
    output logic              any_pend,
    output logic [DATA_W-1:0] vector
);

    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic [IDX_W-1:0] lo_idx;
    logic [IDX_W-1:0] hi_idx;
    logic [IDX_W-1:0] win_idx;

    always_comb begin
        lo_idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend[i]) lo_idx = IDX_W'(i);
        end
        hi_idx = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (pend[i]) hi_idx = IDX_W'(i);
        end
    end

    assign any_pend = |pend;
    assign win_idx  = hi_first ? hi_idx : lo_idx;
    assign vector   = any_pend ? (vbase + (DATA_W'(win_idx) << STRIDE_LOG2)) : vbase;

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
#(
    parameter int N_SRC  = 26,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    input  logic [N_SRC-1:0]      status,
    input  logic [N_SRC-1:0]      masked,
    input  logic [DATA_W-1:0]     vector,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  reg_rvalid,
    output logic [N_SRC-1:0]      edge_mode,
    output logic [N_SRC-1:0]      pos_pol,
    output logic [N_SRC-1:0]      enable,
    output logic [N_SRC-1:0]      to_crit,
    output logic                  hi_first,
    output logic [DATA_W-1:0]     vbase,
    output logic [N_SRC-1:0]      w1c
);

    bus_state_e        state_q;
    bus_state_e        state_d;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_mux;
    reg_sel_e          sel;

    assign sel = reg_sel_e'(reg_addr);

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_mode <= '0;
            pos_pol   <= '1;
            enable    <= '0;
            to_crit   <= '0;
            hi_first  <= 1'b0;
            vbase     <= '0;
        end else if (reg_wr) begin
            case (sel)
                REG_ENABLE: enable    <= reg_wdata[N_SRC-1:0];
                REG_EDGE:   edge_mode <= reg_wdata[N_SRC-1:0];
                REG_POL:    pos_pol   <= reg_wdata[N_SRC-1:0];
                REG_ROUTE:  to_crit   <= reg_wdata[N_SRC-1:0];
                REG_ORDER:  hi_first  <= reg_wdata[0];
                REG_VBASE:  vbase     <= reg_wdata;
                default: ;
            endcase
        end
    end

    assign w1c = (reg_wr && (sel == REG_STATUS)) ? reg_wdata[N_SRC-1:0] : '0;

    always_comb begin
        case (sel)
            REG_STATUS: rd_mux = DATA_W'(status);
            REG_ENABLE: rd_mux = DATA_W'(enable);
            REG_MASKED: rd_mux = DATA_W'(masked);
            REG_EDGE:   rd_mux = DATA_W'(edge_mode);
            REG_POL:    rd_mux = DATA_W'(pos_pol);
            REG_ROUTE:  rd_mux = DATA_W'(to_crit);
            REG_ORDER:  rd_mux = DATA_W'(hi_first);
            REG_VBASE:  rd_mux = vbase;
            REG_VECTOR: rd_mux = vector;
            default:    rd_mux = '0;
        endcase
    end

    // read response state machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (reg_rd) rdata_q <= rd_mux;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (reg_rd)  state_d = BUS_RESP;
            BUS_RESP: if (!reg_rd) state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        reg_rvalid = (state_q == BUS_RESP);
        reg_rdata  = rdata_q;
    end

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_pkg::*;
#(
    parameter int N_EXT       = DEF_N_EXT,
    parameter int N_INT       = DEF_N_INT,
    parameter int DATA_W      = DEF_DATA_W,
    parameter int STRIDE_LOG2 = DEF_STRIDE_LOG2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_EXT-1:0]      ext_irq,
    input  logic [N_INT-1:0]      int_irq,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  reg_rvalid,
    output logic                  irq_noncrit,
    output logic                  irq_crit,
    output logic [DATA_W-1:0]     crit_vector
);

    localparam int N_SRC = N_EXT + N_INT;

    logic [N_EXT-1:0]  ext_sync;
    logic [N_SRC-1:0]  src_raw;
    logic [N_SRC-1:0]  status;
    logic [N_SRC-1:0]  masked;
    logic [N_SRC-1:0]  pend_crit;
    logic [N_SRC-1:0]  edge_mode;
    logic [N_SRC-1:0]  pos_pol;
    logic [N_SRC-1:0]  enable;
    logic [N_SRC-1:0]  to_crit;
    logic [N_SRC-1:0]  w1c;
    logic              hi_first;
    logic [DATA_W-1:0] vbase;
    logic              any_crit;

    irq_sync #(.W(N_EXT)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_irq),
        .sync_out (ext_sync)
    );

    assign src_raw = {int_irq, ext_sync};

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        irq_src_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .raw_in    (src_raw[g]),
            .pos_pol   (pos_pol[g]),
            .edge_mode (edge_mode[g]),
            .clr       (w1c[g]),
            .status    (status[g])
        );
    end

    assign masked      = status & enable;
    assign pend_crit   = masked & to_crit;
    assign irq_noncrit = |(masked & ~to_crit);
    assign irq_crit    = any_crit;

    irq_prio #(
        .N_SRC       (N_SRC),
        .DATA_W      (DATA_W),
        .STRIDE_LOG2 (STRIDE_LOG2)
    ) u_prio (
        .pend     (pend_crit),
        .hi_first (hi_first),
        .vbase    (vbase),
        .any_pend (any_crit),
        .vector   (crit_vector)
    );

    irq_regs #(
        .N_SRC  (N_SRC),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .status     (status),
        .masked     (masked),
        .vector     (crit_vector),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .edge_mode  (edge_mode),
        .pos_pol    (pos_pol),
        .enable     (enable),
        .to_crit    (to_crit),
        .hi_first   (hi_first),
        .vbase      (vbase),
        .w1c        (w1c)
    );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int N_SRC       = 26,
    parameter int DATA_W      = 32,
    parameter int STRIDE_LOG2 = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_rd,
    input logic              reg_rvalid,
    input logic              irq_crit,
    input logic              irq_noncrit,
    input logic [DATA_W-1:0] crit_vector,
    input logic [DATA_W-1:0] vbase,
    input logic [N_SRC-1:0]  status,
    input logic [N_SRC-1:0]  enable,
    input logic [N_SRC-1:0]  edge_mode,
    input logic [N_SRC-1:0]  w1c
);

    localparam logic [DATA_W-1:0] OFS_MASK  = DATA_W'((64'd1 << STRIDE_LOG2) - 64'd1);
    localparam logic [DATA_W-1:0] OFS_LIMIT = DATA_W'(N_SRC) << STRIDE_LOG2;

    logic [DATA_W-1:0] offset;
    assign offset = crit_vector - vbase;

    AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid); // R2
    AST_NO_RVALID_WITHOUT_RD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid); // R2
    AST_VECTOR_IDLE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_crit |-> (crit_vector == vbase)); // R10
    AST_VECTOR_ON_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_crit |-> (((offset & OFS_MASK) == '0) && (offset < OFS_LIMIT))); // R10
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> (!irq_crit && !irq_noncrit)); // R7
    AST_EDGE_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & edge_mode & ~w1c) != '0) |=>
        (($past(status & edge_mode & ~w1c) & edge_mode & ~status) == '0)); // R4

endmodule

bind irq_router irq_router_chk #(
    .N_SRC       (N_SRC),
    .DATA_W      (DATA_W),
    .STRIDE_LOG2 (STRIDE_LOG2)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_rd      (reg_rd),
    .reg_rvalid  (reg_rvalid),
    .irq_crit    (irq_crit),
    .irq_noncrit (irq_noncrit),
    .crit_vector (crit_vector),
    .vbase       (vbase),
    .status      (status),
    .enable      (enable),
    .edge_mode   (edge_mode),
    .w1c         (w1c)
);

// File: tb/irq_router_bench.sv
`timescale 1ns/1ps
module irq_router_bench;

    localparam logic [31:0] ALL  = 32'h03FF_FFFF;
    localparam logic [31:0] BASE = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  ext_irq = '0;
    logic [18:0] int_irq = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        irq_noncrit;
    logic        irq_crit;
    logic [31:0] crit_vector;

    int errs   = 0;
    int checks = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_item_t;
    exp_item_t exp_q[$];

    always #2.5 clk = ~clk;

    irq_router u_irq_router (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_irq     (ext_irq),
        .int_irq     (int_irq),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .reg_rvalid  (reg_rvalid),
        .irq_noncrit (irq_noncrit),
        .irq_crit    (irq_crit),
        .crit_vector (crit_vector)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // driver: issues the read and queues the expected word
    task automatic rd_expect(input logic [3:0] a, input logic [31:0] e, input string tag);
        exp_item_t it;
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        it.val = e; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops and compares on each valid read response
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            exp_item_t it;
            if (exp_q.size() == 0) begin
                checks++; errs++;
                $display("FAIL R2 unexpected rvalid actual=%h expected=none", reg_rdata);
            end else begin
                it = exp_q.pop_front();
                check(it.tag, reg_rdata, it.val);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        cycles(3);
        // R1 reset state
        check("R1 noncrit at reset", 32'(irq_noncrit), 0);
        check("R1 crit at reset", 32'(irq_crit), 0);
        check("R1 vector at reset", crit_vector, 0);
        check("R1 rvalid at reset", 32'(reg_rvalid), 0);
        rst_n = 1'b1;
        cycles(2);
        rd_expect(4'd0, 0, "R1 status reset");
        rd_expect(4'd4, ALL, "R1 polarity reset");
        rd_expect(4'd6, 0, "R1 order reset");

        // R2 write then read back
        wr(4'd1, ALL);
        rd_expect(4'd1, ALL, "R2 enable readback");

        // R3 level mode, on-chip source 7
        @(negedge clk); int_irq[0] = 1'b1;
        @(negedge clk);
        check("R3 level rise one cycle", 32'(irq_noncrit), 1);
        rd_expect(4'd0, 32'h80, "R3 level status");
        wr(4'd0, 32'h80);
        rd_expect(4'd0, 32'h80, "R3 w1c ignored while active");
        @(negedge clk); int_irq[0] = 1'b0;
        @(negedge clk);
        check("R3 level fall one cycle", 32'(irq_noncrit), 0);

        // R6 external source 0 through the synchronizer
        @(negedge clk); ext_irq[0] = 1'b1;
        @(negedge clk);
        check("R6 ext after edge 1", 32'(irq_noncrit), 0);
        @(negedge clk);
        check("R6 ext after edge 2", 32'(irq_noncrit), 0);
        @(negedge clk);
        check("R6 ext after edge 3", 32'(irq_noncrit), 1);
        ext_irq[0] = 1'b0;
        cycles(4);
        check("R6 ext released", 32'(irq_noncrit), 0);

        // R4 edge mode, source 8
        wr(4'd3, 32'h100);
        @(negedge clk); int_irq[1] = 1'b1;
        @(negedge clk); int_irq[1] = 1'b0;
        cycles(2);
        check("R4 edge latched output", 32'(irq_noncrit), 1);
        rd_expect(4'd0, 32'h100, "R4 edge status held");
        wr(4'd0, 32'h100);
        check("R4 w1c clears", 32'(irq_noncrit), 0);
        rd_expect(4'd0, 0, "R4 status after clear");

        // R5 polarity: source 9 low-active level, source 10 falling edge
        @(negedge clk); int_irq[3] = 1'b1;
        wr(4'd4, ALL & ~32'h600);
        wr(4'd3, 32'h400);
        rd_expect(4'd0, 32'h200, "R5 low level active");
        @(negedge clk); int_irq[2] = 1'b1;
        @(negedge clk); int_irq[3] = 1'b0;
        @(negedge clk); int_irq[3] = 1'b1;
        @(negedge clk);
        rd_expect(4'd0, 32'h400, "R5 falling edge latched");
        @(negedge clk); int_irq[3] = 1'b0;
        @(negedge clk);
        wr(4'd0, 32'h400);
        @(negedge clk); int_irq[2] = 1'b0;
        wr(4'd4, ALL);
        wr(4'd3, 32'h0);
        rd_expect(4'd0, 0, "R5 restored quiet");

        // R7 enable mask, source 11
        wr(4'd1, 32'h0);
        @(negedge clk); int_irq[4] = 1'b1;
        @(negedge clk);
        check("R7 disabled noncrit", 32'(irq_noncrit), 0);
        check("R7 disabled crit", 32'(irq_crit), 0);
        rd_expect(4'd0, 32'h800, "R7 raw status kept");
        rd_expect(4'd2, 32'h0, "R7 masked zero");
        wr(4'd1, 32'h800);
        check("R7 enabled noncrit", 32'(irq_noncrit), 1);
        rd_expect(4'd2, 32'h800, "R7 masked set");
        @(negedge clk); int_irq[4] = 1'b0;
        wr(4'd1, ALL);

        // R8 routing, source 12 critical
        wr(4'd7, BASE);
        wr(4'd5, 32'h1000);
        @(negedge clk); int_irq[5] = 1'b1;
        @(negedge clk);
        check("R8 crit raised", 32'(irq_crit), 1);
        check("R8 noncrit quiet", 32'(irq_noncrit), 0);
        check("R10 vector src12", crit_vector, BASE + 32'd12 * 32'd512);

        // R9 priority among sources 3, 12, 20
        wr(4'd5, 32'h0010_1008);
        @(negedge clk); int_irq[13] = 1'b1;
        @(negedge clk);
        check("R9 lowest wins", crit_vector, BASE + 32'd12 * 32'd512);
        wr(4'd6, 32'h1);
        check("R9 highest wins", crit_vector, BASE + 32'd20 * 32'd512);
        rd_expect(4'd6, 32'h1, "R9 order readback");
        @(negedge clk); ext_irq[3] = 1'b1;
        cycles(3);
        check("R9 highest still wins", crit_vector, BASE + 32'd20 * 32'd512);
        wr(4'd6, 32'h0);
        check("R9 lowest ext wins", crit_vector, BASE + 32'd3 * 32'd512);
        rd_expect(4'd8, BASE + 32'd3 * 32'd512, "R10 vector readback");
        check("R8 noncrit while all critical", 32'(irq_noncrit), 0);

        // R10 idle vector
        @(negedge clk); int_irq[5] = 1'b0; int_irq[13] = 1'b0; ext_irq[3] = 1'b0;
        cycles(4);
        check("R10 crit idle", 32'(irq_crit), 0);
        check("R10 vector idle base", crit_vector, BASE);
        rd_expect(4'd8, BASE, "R10 idle vector readback");

        cycles(3);
        if (exp_q.size() != 0) begin
            checks++; errs++;
            $display("FAIL R2 missing responses actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule